// File: doc/BRIEF.md
# Serial SRAM SPI Slave Controller

This block is the slave side of a byte-organised serial SRAM that is reached over a single-lane SPI link in mode 0. Its clock is the chip's system clock. It samples the chip select, serial clock and serial data pins through a short synchroniser chain and finds the serial clock edges by comparing successive samples. An 8-bit opcode starts each transaction. For memory accesses a 24-bit address follows the opcode. Data then moves between the pins and a synchronous single-port RAM of 8-bit words. Each access uses an internal pointer, and after each byte the pointer steps according to the access mode held in a small mode register.

The controller is one state machine. ST_IDLE waits while chip select is high. ST_CMD collects the opcode. From ST_CMD the machine moves to ST_ADDR for a read or write, to ST_MRD for a mode register read, to ST_MWR for a mode register write, and to ST_SKIP for any other opcode. ST_ADDR collects 24 address bits, then moves to ST_RDATA or ST_WDATA. In byte mode the data states move to ST_SKIP after one byte. ST_MRD and ST_MWR move to ST_SKIP after eight bits. ST_SKIP holds until chip select rises. From any state, chip select going high sends the machine to ST_IDLE.

The serial clock must stay high for at least 4 system clock cycles and low for at least 4 system clock cycles. This gives the two-cycle array fetch time to finish before the next output bit is due.

Top module: `sram_spi_slave`

## Requirements
- R1: Opcode 0x03 reads the array and opcode 0x02 writes it. Opcode 0x05 returns the mode register as one byte on the serial output. Opcode 0x01 loads the mode register from the next byte.
- R2: Opcode, address and data bits are sampled on the serial clock's rising edge, most significant bit first. Of the 24 address bits only the low 17 select a word, and the upper 7 have no effect.
- R3: The serial output changes only after a falling serial clock edge and sends the most significant bit first. The output enable stays low during the opcode and address phases and is high only while read data or mode data is being sent.
- R4: Mode bits 7:6 select the access mode: 00 is byte, 10 is page, 01 is sequential. After reset the mode is sequential, so a mode read gives 0x40. Writing 11 selects byte mode. The low six bits read back as zero.
- R5: In byte mode one data byte moves per transaction. Later write bytes are not stored, and during later read bytes the output enable stays low.
- R6: In page mode the pointer steps within the addressed 32-word page, and after word 31 it returns to word 0 of that same page.
- R7: In sequential mode the pointer crosses page boundaries and rolls from 0x1FFFF to 0x00000, for reads and for writes.
- R8: A write byte reaches the array only after all eight of its bits have arrived. A byte cut short by chip select going high is discarded.
- R9: Chip select going high ends any transaction and forces the output enable low. The next transaction starts again from the opcode.
- R10: The dual-lane entry opcode 0x3B, the quad-lane entry opcode 0x38, the lane reset opcode 0xFF and any unknown opcode cause no array write, no mode change and no output, until chip select rises.
- R11: The RAM port is registered. Read data is taken one cycle after the read strobe, and the read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master (idles low) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high-impedance |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_rdata | input | 8 | RAM read data, valid the cycle after mem_re |

## Verification
The hardest states to reach from the pins are the two wrap points and a write byte cut short by chip select. The page wrap is reached by writing and then reading a burst that starts one or two words below a page end while page mode is set. The array rollover is reached the same way by starting at 0x1FFFE in sequential mode. To cut a byte short, the bench clocks only a few bits of a data byte before it raises chip select. It then counts the RAM write strobes and inspects its own array model to confirm that nothing or exactly one byte landed.

// File: rtl/sram_spi_pkg.sv
`timescale 1ns/1ps
package sram_spi_pkg;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_RDMODE = 8'h05;
    localparam logic [7:0] OP_WRMODE = 8'h01;

    localparam int ADDR_BITS = 24;
    localparam int CNT_W     = $clog2(ADDR_BITS);

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_SEQ  = 2'b01,
        MODE_PAGE = 2'b10,
        MODE_RSVD = 2'b11
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_MRD,
        ST_MWR,
        ST_SKIP
    } sstate_e;

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_n_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] cs_pipe, ck_pipe, d_pipe;
    logic              ck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe <= '1;
            ck_pipe <= '0;
            d_pipe  <= '0;
            ck_last <= 1'b0;
        end else begin
            cs_pipe <= {cs_pipe[STAGES-2:0], cs_n};
            ck_pipe <= {ck_pipe[STAGES-2:0], sclk};
            d_pipe  <= {d_pipe[STAGES-2:0], mosi};
            ck_last <= ck_pipe[STAGES-1];
        end
    end

    assign cs_n_s   = cs_pipe[STAGES-1];
    assign mosi_s   = d_pipe[STAGES-1];
    assign sck_rise = ck_pipe[STAGES-1] & ~ck_last;
    assign sck_fall = ~ck_pipe[STAGES-1] & ck_last;
endmodule

// File: rtl/sram_ptr_step.sv
`timescale 1ns/1ps
module sram_ptr_step
    import sram_spi_pkg::*;
#(
    parameter int AW     = 17,
    parameter int PAGE_W = 5
) (
    input  logic [AW-1:0] ptr,
    input  acc_mode_e     mode,
    output logic [AW-1:0] nxt
);
    always_comb begin
        unique case (mode)
            MODE_PAGE: nxt = {ptr[AW-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + PAGE_W'(1))};
            default:   nxt = ptr + AW'(1);
        endcase
    end
endmodule

// File: rtl/sram_spi_slave.sv
`timescale 1ns/1ps
module sram_spi_slave
    import sram_spi_pkg::*;
#(
    parameter int AW          = 17,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [7:0]    mem_rdata
);
    logic             cs_n_s, mosi_s, sck_rise, sck_fall;
    sstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [6:0]       sh_q;
    logic [7:0]       out_sh_q;
    logic [AW-1:0]    ptr_q, ptr_nxt;
    acc_mode_e        mode_q;
    logic             is_rd_q, rd_wait_q;

    logic [7:0]    byte_in;
    logic [AW-1:0] ptr_load;
    logic          last_bit, rd_phase, shifting;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    sram_ptr_step #(.AW(AW), .PAGE_W(PAGE_W)) u_step (
        .ptr(ptr_q), .mode(mode_q), .nxt(ptr_nxt)
    );

    assign byte_in  = {sh_q, mosi_s};
    assign ptr_load = {ptr_q[AW-2:0], mosi_s};
    assign last_bit = (state_q == ST_ADDR) ? (cnt_q == CNT_W'(ADDR_BITS - 1))
                                           : (cnt_q == CNT_W'(7));
    assign rd_phase = (state_q == ST_RDATA) || (state_q == ST_MRD);
    assign shifting = (state_q != ST_IDLE) && (state_q != ST_SKIP);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: if (sck_rise && last_bit) begin
                    case (byte_in)
                        OP_READ, OP_WRITE: state_d = ST_ADDR;
                        OP_RDMODE:         state_d = ST_MRD;
                        OP_WRMODE:         state_d = ST_MWR;
                        default:           state_d = ST_SKIP;
                    endcase
                end
                ST_ADDR: if (sck_rise && last_bit)
                    state_d = is_rd_q ? ST_RDATA : ST_WDATA;
                ST_RDATA, ST_WDATA: if (sck_rise && last_bit && mode_q == MODE_BYTE)
                    state_d = ST_SKIP;
                ST_MRD, ST_MWR: if (sck_rise && last_bit)
                    state_d = ST_SKIP;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            sh_q        <= '0;
            out_sh_q    <= '0;
            ptr_q       <= '0;
            mode_q      <= MODE_SEQ;
            is_rd_q     <= 1'b0;
            rd_wait_q   <= 1'b0;
            spi_miso    <= 1'b0;
            spi_miso_oe <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
            mem_we      <= 1'b0;
            mem_re      <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            rd_wait_q <= mem_re;
            if (cs_n_s || !shifting) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                sh_q  <= byte_in[6:0];
                cnt_q <= last_bit ? '0 : cnt_q + CNT_W'(1);
            end
            if (!cs_n_s && sck_rise) begin
                unique case (state_q)
                    ST_CMD: if (last_bit) begin
                        is_rd_q <= (byte_in == OP_READ);
                        if (byte_in == OP_RDMODE) out_sh_q <= {mode_q, 6'b0};
                    end
                    ST_ADDR: begin
                        ptr_q <= ptr_load;
                        if (last_bit && is_rd_q) begin
                            mem_re   <= 1'b1;
                            mem_addr <= ptr_load;
                        end
                    end
                    ST_WDATA: if (last_bit) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= ptr_q;
                        mem_wdata <= byte_in;
                        ptr_q     <= ptr_nxt;
                    end
                    ST_RDATA: if (last_bit && mode_q != MODE_BYTE) begin
                        ptr_q    <= ptr_nxt;
                        mem_re   <= 1'b1;
                        mem_addr <= ptr_nxt;
                    end
                    ST_MWR: if (last_bit)
                        mode_q <= (byte_in[7:6] == 2'b11) ? MODE_BYTE : acc_mode_e'(byte_in[7:6]);
                    default: ;
                endcase
            end
            if (cs_n_s || !rd_phase) begin
                spi_miso_oe <= 1'b0;
            end else if (sck_fall) begin
                spi_miso    <= out_sh_q[7];
                out_sh_q    <= {out_sh_q[6:0], 1'b0};
                spi_miso_oe <= 1'b1;
            end
            if (rd_wait_q) out_sh_q <= mem_rdata;
        end
    end

    // R9: deselection forces the output to high-impedance on the next cycle
    a_r9_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !spi_miso_oe);

    // R3: no output drive outside the data-out phases
    a_r3_hiz_outside_readout: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_phase |=> !spi_miso_oe);

    // R11: read and write strobes are exclusive
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8: a write strobe only follows a cycle spent collecting write data
    a_r8_write_from_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(state_q) == ST_WDATA);

    // R10: a skipped transaction never touches the array
    a_r10_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && $past(state_q) == ST_SKIP) |-> !mem_we);
endmodule

// File: tb/sram_spi_slave_bench.sv
`timescale 1ns/1ps
module sram_spi_slave_bench;
    localparam int AW   = 17;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    int checks = 0, errors = 0;
    int we_cnt = 0, both_cnt = 0, unstable_cnt = 0;
    bit done = 1'b0;
    logic [7:0] model [int unsigned];
    logic [7:0] rx_byte, rx_oe;
    logic [7:0] rbuf [0:7];
    logic [7:0] roe  [0:7];
    logic hdr_oe;

    always #2.5 clk = ~clk;

    sram_spi_slave #(.AW(AW)) u_sram_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    initial mem_rdata = 8'h00;
    always @(posedge clk) begin
        if (mem_we) begin
            model[32'(mem_addr)] = mem_wdata;
            we_cnt++;
        end
        if (mem_re) mem_rdata <= model.exists(32'(mem_addr)) ? model[32'(mem_addr)] : 8'h00;
        if (mem_we && mem_re) both_cnt++;
    end

    function automatic logic [7:0] peek(input int unsigned a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n);
        for (int i = 0; i < n; i++) begin
            logic s0, o0;
            mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            s0 = miso; o0 = miso_oe;
            rx_byte[7-i] = s0; rx_oe[7-i] = o0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (o0 && miso_oe && miso !== s0) unstable_cnt++;
            sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx);
        rx_oe = 8'h00;
        spi_bits(tx, 8);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1; mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] acc;
        spi_byte(op);        acc = rx_oe;
        spi_byte(a[23:16]);  acc |= rx_oe;
        spi_byte(a[15:8]);   acc |= rx_oe;
        spi_byte(a[7:0]);    acc |= rx_oe;
        hdr_oe = |acc;
    endtask

    task automatic do_write(input logic [23:0] a, input int n, input logic [7:0] d0);
        sel();
        send_hdr(8'h02, a);
        for (int i = 0; i < n; i++) spi_byte(8'(d0 + i));
        desel();
    endtask

    task automatic do_read(input logic [23:0] a, input int n);
        sel();
        send_hdr(8'h03, a);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00);
            rbuf[i] = rx_byte; roe[i] = rx_oe;
        end
        desel();
    endtask

    task automatic wrmr(input logic [7:0] v);
        sel(); spi_byte(8'h01); spi_byte(v); desel();
    endtask

    task automatic rdmr(output logic [7:0] v, output logic [7:0] oe);
        sel(); spi_byte(8'h05); spi_byte(8'h00); v = rx_byte; oe = rx_oe; desel();
    endtask

    task automatic t_reset();
        logic [7:0] v, oe;
        check("R9 idle output enable", miso_oe, 0);
        check("R11 idle write strobe", mem_we, 0);
        rdmr(v, oe);
        check("R4 reset mode value", v, 8'h40);
        check("R1 mode read drives all bits", oe, 8'hFF);
    endtask

    task automatic t_sequential();
        do_write(24'hFE0100, 3, 8'h11);
        check("R2 upper address bits ignored", peek(32'h100), 8'h11);
        check("R2 second byte", peek(32'h102), 8'h13);
        do_read(24'h000100, 3);
        check("R3 high-z in opcode/address", hdr_oe, 0);
        check("R1 read byte 0", rbuf[0], 8'h11);
        check("R1 read byte 1", rbuf[1], 8'h12);
        check("R1 read byte 2", rbuf[2], 8'h13);
        check("R3 data driven", roe[2], 8'hFF);
        check("R3 output changes on falling edge only", unstable_cnt, 0);
    endtask

    task automatic t_rollover();
        do_write(24'h01FFFE, 4, 8'hA0);
        check("R7 write at top", peek(32'h1FFFF), 8'hA1);
        check("R7 write rolls to zero", peek(32'h0), 8'hA2);
        check("R7 write continues", peek(32'h1), 8'hA3);
        do_read(24'h01FFFF, 2);
        check("R7 read at top", rbuf[0], 8'hA1);
        check("R7 read rolls to zero", rbuf[1], 8'hA2);
    endtask

    task automatic t_page();
        logic [7:0] v, oe;
        wrmr(8'h80);
        rdmr(v, oe);
        check("R4 page mode readback", v, 8'h80);
        do_write(24'h00041E, 3, 8'h50);
        check("R6 page word 31", peek(32'h41F), 8'h51);
        check("R6 page wraps to word 0", peek(32'h400), 8'h52);
        check("R6 next page untouched", peek(32'h420), 8'h00);
        do_read(24'h00041F, 3);
        check("R6 read word 31", rbuf[0], 8'h51);
        check("R6 read wraps to word 0", rbuf[1], 8'h52);
        check("R6 read word 1", rbuf[2], 8'h00);
    endtask

    task automatic t_byte();
        logic [7:0] v, oe;
        int w0;
        wrmr(8'h00);
        rdmr(v, oe);
        check("R4 byte mode readback", v, 8'h00);
        w0 = we_cnt;
        do_write(24'h000200, 2, 8'h77);
        check("R5 single write strobe", we_cnt - w0, 1);
        check("R5 first byte stored", peek(32'h200), 8'h77);
        check("R5 second byte dropped", peek(32'h201), 8'h00);
        do_read(24'h000200, 2);
        check("R5 first read byte", rbuf[0], 8'h77);
        check("R5 no drive after byte", roe[1], 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v, oe;
        wrmr(8'hC0);
        rdmr(v, oe);
        check("R4 reserved code is byte mode", v, 8'h00);
        wrmr(8'h7F);
        rdmr(v, oe);
        check("R4 low bits read zero", v, 8'h40);
    endtask

    task automatic t_partial();
        int w0;
        w0 = we_cnt;
        sel(); send_hdr(8'h02, 24'h000300); spi_bits(8'hEE, 5); desel();
        check("R8 partial byte no strobe", we_cnt - w0, 0);
        check("R8 partial byte not stored", peek(32'h300), 8'h00);
        w0 = we_cnt;
        sel(); send_hdr(8'h02, 24'h000301); spi_byte(8'h9C); spi_bits(8'hFF, 3); desel();
        check("R8 full byte committed once", we_cnt - w0, 1);
        check("R8 full byte value", peek(32'h301), 8'h9C);
        check("R8 trailing bits dropped", peek(32'h302), 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] ops [0:3];
        logic [7:0] v, oe, acc;
        int w0;
        ops[0] = 8'h3B; ops[1] = 8'h38; ops[2] = 8'hFF; ops[3] = 8'h55;
        w0 = we_cnt; acc = 8'h00;
        for (int k = 0; k < 4; k++) begin
            sel();
            spi_byte(ops[k]); acc |= rx_oe;
            spi_byte(8'h02);  acc |= rx_oe;
            spi_byte(8'h01);  acc |= rx_oe;
            spi_byte(8'h80);  acc |= rx_oe;
            spi_byte(8'h00);  acc |= rx_oe;
            desel();
        end
        check("R10 no array write", we_cnt - w0, 0);
        check("R10 no output drive", acc, 8'h00);
        rdmr(v, oe);
        check("R10 mode unchanged", v, 8'h40);
    endtask

    task automatic t_abort();
        logic [7:0] v, oe;
        do_write(24'h000500, 3, 8'h31);
        sel(); send_hdr(8'h03, 24'h000500); spi_byte(8'h00); v = rx_byte; spi_bits(8'h00, 4); desel();
        check("R9 first byte before abort", v, 8'h31);
        check("R9 output released after deselect", miso_oe, 0);
        do_read(24'h000501, 1);
        check("R9 fresh transaction after abort", rbuf[0], 8'h32);
        rdmr(v, oe);
        check("R9 mode read after abort", v, 8'h40);
        check("R11 strobes never overlap", both_cnt, 0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_sequential();
        t_rollover();
        t_page();
        t_byte();
        t_reserved();
        t_partial();
        t_ignored();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule